// File: doc/BRIEF.md
# Distributed Arithmetic Dot-Product Engine

This block forms the dot product of a vector of signed integer operands with a fixed vector of signed coefficients, and it uses no multiplier. A table holds every possible sum of coefficients, one entry for each subset. On each step the block takes one bit-plane of the operands, meaning the same bit position from every operand. That bit-plane addresses the table, and the block adds the partial sum it reads back into an accumulator at the weight of that bit position. The most significant plane carries negative weight in two's complement, so the block subtracts its partial sum.

The parameter `K` sets how many bit-planes the block consumes per clock. It holds `K` identical copies of the table, each with one registered read port, and runs `XW/K` steps. Setting `K = XW` gives a single-step engine. The table has a write port, and the coefficient set is replaced by rewriting it between computations. The controller and datapath stay the same for any coefficient set.

The user drives all operands in parallel and pulses `start`. The block raises `busy` while it works. When the result is ready it presents it on `result` together with a one-cycle `done` strobe.

Top module: `da_dot`

## Requirements
- R1: Operand i occupies `x_in[i*XW +: XW]`. Table entry a holds the sum of coefficient i over every i whose bit i of a is 1. When `done` is high, `result` equals the sum of coefficient i times operand i.
- R2: `done` rises exactly `XW/K + 1` clock cycles after the edge that accepted `start`, and `busy` is high throughout that interval.
- R3: Operands are two's complement. Bit XW-1 carries weight -2^(XW-1), so negative operands produce correctly signed results.
- R4: `done` is high for exactly one cycle. `result` keeps its value until the next `done`.
- R5: A `start` pulse while `busy` is high is ignored. The running computation keeps its operands and timing, and no extra `done` follows.
- R6: Table writes take effect only while `busy` is low, so a write attempted during a computation leaves the table unchanged. Rewriting the table while idle changes the coefficient set used by the next computation.
- R7: After synchronous reset, `busy`, `done` and `result` are all zero.
- R8: The accumulator is `XW + CW + ceil(log2 N_IN)` bits wide. The most negative operands combined with the most negative coefficients produce the exact result without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation with the current `x_in` |
| x_in | input | N_IN*XW | Packed signed operands; operand i at bits i*XW and up |
| tbl_we | input | 1 | Table write enable (honoured only while idle) |
| tbl_addr | input | N_IN | Table entry index; bit i selects coefficient i |
| tbl_wdata | input | CW+clog2(N_IN) | Signed partial-sum value to store |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle strobe: `result` is valid |
| result | output | XW+CW+clog2(N_IN) | Signed dot product, held until the next `done` |

## Verification
Each operand position is swept in turn through its full signed range while the other operands stay at fixed mixed-sign values. This separates errors in bit-plane weighting from errors in address bit ordering, and the negative half of each sweep isolates the subtracted sign plane. An all-minus-one operand vector drives the all-ones address on every plane. The most negative operands against the most negative coefficients probe accumulator headroom. Runs with a second coefficient set, with a table write attempted mid-computation and with a start pulse issued mid-computation separate correct reload and ignore behaviour from corruption of the running result or of later results.

// File: rtl/da_pkg.sv
`timescale 1ns/1ps
package da_pkg;
  typedef enum logic [1:0] {
    DA_IDLE  = 2'd0,
    DA_RUN   = 2'd1,
    DA_DRAIN = 2'd2
  } da_state_e;
endpackage

// File: rtl/da_ctrl.sv
`timescale 1ns/1ps
module da_ctrl #(
  parameter int STEPS = 4,
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          accept,
  output logic          issue,
  output logic [SW-1:0] step,
  output logic          rd_valid,
  output logic          rd_last,
  output logic [SW-1:0] rd_step
);
  import da_pkg::*;

  localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);

  da_state_e state_q;
  logic [SW-1:0] step_q;

  always_comb begin
    busy   = (state_q != DA_IDLE);
    accept = (state_q == DA_IDLE) && start;
    issue  = (state_q == DA_RUN);
    step   = step_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= DA_IDLE;
      step_q   <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_step  <= '0;
    end else begin
      rd_valid <= issue;
      rd_last  <= issue && (step_q == LAST_STEP);
      rd_step  <= step_q;
      case (state_q)
        DA_IDLE: begin
          if (start) begin
            state_q <= DA_RUN;
            step_q  <= '0;
          end
        end
        DA_RUN: begin
          if (step_q == LAST_STEP) begin
            state_q <= DA_DRAIN;
            step_q  <= '0;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: state_q <= DA_IDLE;
      endcase
    end
  end

  // R2: the final table read is always absorbed while draining
  a_r2_last_in_drain: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> (state_q == DA_DRAIN));

endmodule

// File: rtl/da_table.sv
`timescale 1ns/1ps
module da_table #(
  parameter int N_IN  = 4,
  parameter int TW    = 10,
  parameter int PORTS = 2,
  localparam int DEPTH = 1 << N_IN
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [N_IN-1:0]       waddr,
  input  logic [TW-1:0]         wdata,
  input  logic                  re,
  input  logic [PORTS*N_IN-1:0] raddr,
  output logic [PORTS*TW-1:0]   rdata
);
  // One copy per read port; every copy sees the same writes.
  for (genvar p = 0; p < PORTS; p++) begin : g_copy
    logic [TW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
      if (re) rdata[p*TW +: TW] <= mem[raddr[p*N_IN +: N_IN]];
    end
  end

endmodule

// File: rtl/da_accum.sv
`timescale 1ns/1ps
module da_accum #(
  parameter int K     = 2,
  parameter int XW    = 8,
  parameter int TW    = 10,
  parameter int ACCW  = 18,
  parameter int STEPS = 4,
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clear,
  input  logic                   valid,
  input  logic                   last,
  input  logic [SW-1:0]          step,
  input  logic [K*TW-1:0]        rdata,
  output logic signed [ACCW-1:0] result,
  output logic                   done
);
  logic signed [ACCW-1:0] acc_q;
  logic signed [ACCW-1:0] acc_next;

  always_comb begin
    acc_next = acc_q;
    for (int k = 0; k < K; k++) begin
      int plane;
      logic signed [ACCW-1:0] term;
      plane = int'(step) * K + k;
      term  = ACCW'($signed(rdata[k*TW +: TW]));
      term  = term <<< plane;
      if (plane == XW - 1) acc_next = acc_next - term;
      else                 acc_next = acc_next + term;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clear) begin
        acc_q <= '0;
      end else if (valid) begin
        acc_q <= acc_next;
        if (last) begin
          result <= acc_next;
          done   <= 1'b1;
        end
      end
    end
  end

  // R4: strobe is a single cycle
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: result only moves together with the strobe
  a_r4_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

endmodule

// File: rtl/da_dot.sv
`timescale 1ns/1ps
module da_dot #(
  parameter int N_IN = 4,
  parameter int XW   = 8,
  parameter int CW   = 8,
  parameter int K    = 2,
  localparam int LOGN  = (N_IN > 1) ? $clog2(N_IN) : 0,
  localparam int TW    = CW + LOGN,
  localparam int ACCW  = XW + TW,
  localparam int STEPS = XW / K,
  localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [N_IN*XW-1:0]     x_in,
  input  logic                   tbl_we,
  input  logic [N_IN-1:0]        tbl_addr,
  input  logic [TW-1:0]          tbl_wdata,
  output logic                   busy,
  output logic                   done,
  output logic signed [ACCW-1:0] result
);
  if (XW % K != 0) begin : g_bad_k
    $error("da_dot: K must divide XW");
  end

  logic                 accept, issue, rd_valid, rd_last;
  logic [SW-1:0]        step, rd_step;
  logic [N_IN*XW-1:0]   x_q;
  logic [K*N_IN-1:0]    raddr;
  logic [K*TW-1:0]      rdata;
  logic                 wr_go;

  da_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .accept(accept), .issue(issue), .step(step),
    .rd_valid(rd_valid), .rd_last(rd_last), .rd_step(rd_step)
  );

  always_ff @(posedge clk) begin
    if (rst)         x_q <= '0;
    else if (accept) x_q <= x_in;
  end

  // Address for each plane: bit i comes from operand i.
  always_comb begin
    raddr = '0;
    for (int k = 0; k < K; k++) begin
      for (int i = 0; i < N_IN; i++) begin
        raddr[k*N_IN + i] = x_q[i*XW + int'(step)*K + k];
      end
    end
  end

  assign wr_go = tbl_we && !busy;

  da_table #(.N_IN(N_IN), .TW(TW), .PORTS(K)) u_table (
    .clk(clk), .we(wr_go), .waddr(tbl_addr), .wdata(tbl_wdata),
    .re(issue), .raddr(raddr), .rdata(rdata)
  );

  da_accum #(.K(K), .XW(XW), .TW(TW), .ACCW(ACCW), .STEPS(STEPS)) u_accum (
    .clk(clk), .rst(rst), .clear(accept), .valid(rd_valid), .last(rd_last),
    .step(rd_step), .rdata(rdata), .result(result), .done(done)
  );

  // Checker: cycles since the accepted start
  logic [SW+1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (rst)         lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy)   lat_cnt <= lat_cnt + 1'b1;
  end

  // R2: fixed latency from accept to strobe
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == (SW+2)'(STEPS + 1)));

  // R5: latched operands cannot change mid-computation
  a_r5_operands_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(x_q));

endmodule

// File: tb/tb_da_dot.sv
`timescale 1ns/1ps
module tb_da_dot;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int K  = 2;
  localparam int S  = W / K;
  localparam int TW = 10;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N*W-1:0] x_in = '0;
  logic tbl_we = 1'b0;
  logic [N-1:0] tbl_addr = '0;
  logic [TW-1:0] tbl_wdata = '0;
  logic busy, done;
  logic signed [AW-1:0] result;

  int checks = 0;
  int errors = 0;
  int coef[N];
  int xv[N];

  always #2.5 clk = ~clk;

  da_dot dut (
    .clk(clk), .rst(rst), .start(start), .x_in(x_in),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .busy(busy), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint dot_exp();
    longint s = 0;
    for (int i = 0; i < N; i++) s += longint'(coef[i]) * longint'(xv[i]);
    return s;
  endfunction

  task automatic load_table();
    for (int a = 0; a < (1 << N); a++) begin
      int s = 0;
      for (int i = 0; i < N; i++) if (a[i]) s += coef[i];
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = N'(a); tbl_wdata = TW'(s);
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // mode 0: plain, 1: extra start while busy, 2: table write while busy
  task automatic run_op(input int mode, input string req);
    int cyc;
    longint exp;
    exp = dot_exp();
    @(negedge clk);
    for (int i = 0; i < N; i++) x_in[i*W +: W] = W'(xv[i]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    if (mode == 1) begin
      x_in = ~x_in;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end else if (mode == 2) begin
      tbl_we = 1'b1; tbl_addr = '1; tbl_wdata = '0;
      @(negedge clk);
      tbl_we = 1'b0;
      cyc++;
    end
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    check(done == 1'b1, "R2 done arrives", longint'(done), 1);
    check(cyc == S + 2, "R2 latency", longint'(cyc - 1), longint'(S + 1));
    check(longint'(result) == exp, req, longint'(result), exp);
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", longint'(done), 0);
    check(longint'(result) == exp, "R4 result held", longint'(result), exp);
    if (mode == 1) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R5 no second run", longint'(done), 0);
      end
    end
  endtask

  task automatic sweep(input int b0, input int b1, input int b2, input int b3);
    for (int pos = 0; pos < N; pos++) begin
      for (int v = -(1 << (W-1)); v < (1 << (W-1)); v++) begin
        xv[0] = b0; xv[1] = b1; xv[2] = b2; xv[3] = b3;
        xv[pos] = v;
        run_op(0, (v < 0) ? "R1 R3 signed sweep" : "R1 sweep");
      end
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R7 busy reset", longint'(busy), 0);
    check(done == 1'b0, "R7 done reset", longint'(done), 0);
    check(result == '0, "R7 result reset", longint'(result), 0);
    rst = 1'b0;

    coef[0] = 3; coef[1] = -7; coef[2] = 127; coef[3] = -128;
    load_table();
    sweep(37, -91, 5, -128);

    xv[0] = -1; xv[1] = -1; xv[2] = -1; xv[3] = -1;
    run_op(0, "R1 R3 all ones address");

    // R5: start during busy ignored
    xv[0] = 100; xv[1] = -3; xv[2] = 42; xv[3] = -77;
    run_op(1, "R5 result from first operands");

    // R6: write during busy ignored, then verify all-ones entry intact
    xv[0] = 12; xv[1] = -45; xv[2] = 99; xv[3] = 1;
    run_op(2, "R6 result during blocked write");
    xv[0] = -1; xv[1] = -1; xv[2] = -1; xv[3] = -1;
    run_op(0, "R6 table unchanged after blocked write");

    // R6: reload with a second coefficient set
    coef[0] = -1; coef[1] = 64; coef[2] = -33; coef[3] = 100;
    load_table();
    for (int v = -128; v < 128; v += 3) begin
      xv[0] = v; xv[1] = -v - 1; xv[2] = (v * 7) % 128; xv[3] = 55;
      run_op(0, "R6 R1 reloaded coefficients");
    end

    // R8: extreme magnitudes
    coef[0] = -128; coef[1] = -128; coef[2] = -128; coef[3] = -128;
    load_table();
    xv[0] = -128; xv[1] = -128; xv[2] = -128; xv[3] = -128;
    run_op(0, "R8 max positive");
    xv[0] = 127; xv[1] = 127; xv[2] = 127; xv[3] = 127;
    run_op(0, "R8 max negative");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule